// File: doc/BRIEF.md
# Symbolic-Addressed Speculative Data Cache

This block is a small set-associative data cache that is indexed and tagged by a symbolic address rather than a memory address. The symbolic address is built upstream from the base register number and the displacement of a load or store. A load probes the cache early in the pipeline and gets a speculative value back in the same cycle, with no address generation and no access to the real data cache. Stores write into the cache, so a later load that uses the same register and displacement finds the stored value.

When a load misses, the block raises a miss request that carries the symbolic address. The surrounding logic fetches the real line and returns it together with the byte offset of the requested data inside that real line. The block rotates the returned line so that the requested unit lands at its symbolic offset and keeps the distance of every other unit from that target unit. Units that would fall outside the symbolic line are discarded. The line is then only partly valid, and each unit has its own valid bit. The alignment unit is either a 4-byte word or a single byte, selected by a parameter.

Top module: `symc_cache`

## Requirements
- R1: After reset every load misses: `hit_o` is low, `rdata_o` is zero and `miss_req_o` is high, with `miss_addr_o` equal to the load address. This also holds for lines that were filled before a reset.
- R2: A load hits in the same cycle it is presented when the tag matches and every unit that covers its bytes is valid. `req_size_i` encodes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Line byte p is held in bits [8p+7:8p]. The bytes are returned little-endian, right-justified in `rdata_o`, and the unused upper bytes are zero.
- R3: A fill places real unit k at symbolic unit k − r + s. Here r is `fill_real_off_i` divided by the unit size, and s is the offset field of `fill_addr_i` (bits 5:0) divided by the unit size.
- R4: Units whose rotated position falls below 0 or above the last unit are left invalid, and a load that touches any of them misses.
- R5: A store whose tag is present writes its bytes and marks the covering units valid. Other valid units keep their data. A store never raises `miss_req_o`.
- R6: A store whose tag is absent allocates a way and clears all of that way's valid bits. Only the units covering the stored bytes become valid.
- R7: A fill reuses the way that already holds the same tag, or else takes the replacement victim. In both cases all previous valid bits of that way are cleared first.
- R8: Within a set, the replacement victim is the way that was least recently touched by a load hit, a store or a fill.
- R9: When a fill and a store occur in the same cycle, the fill is performed and the store is dropped.
- R10: With `UNIT_BYTES` = 1, alignment and valid tracking are done per byte. With `UNIT_BYTES` = 4, they are done per 4-byte word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load or store request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_addr_i | input | SYM_W (22) | Symbolic address {tag, index, offset} |
| req_wdata_i | input | 32 | Store data, right-justified |
| hit_o | output | 1 | Load hit, same cycle |
| rdata_o | output | 32 | Speculative load data |
| miss_req_o | output | 1 | Load missed, fill wanted |
| miss_addr_o | output | SYM_W (22) | Symbolic address of the missing load |
| fill_valid_i | input | 1 | Fill line present |
| fill_addr_i | input | SYM_W (22) | Symbolic address the fill belongs to |
| fill_real_off_i | input | 6 | Byte offset of the target inside the real line |
| fill_line_i | input | 512 | Real line, byte p at bits [8p+7:8p] |

## Verification
The hardest situation to reach is a line that is valid for only part of its length. The invalid region has to sit at either end of the line, so stimulus must produce both a positive and a negative rotation. The directed fills pair symbolic and real offsets that push the line both ways, including a fill that keeps a single unit. Loads then probe each boundary unit on both sides. Replacement order is reached by filling one set with four tags and touching one of them before a fifth fill. A second instance built with byte units receives the same stimulus, so that a byte-granular rotation can be checked against the word-granular result.

// File: rtl/symc_pkg.sv
package symc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int DATA_BYTES = 4;

  function automatic int size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return DATA_BYTES;
    endcase
  endfunction

endpackage

// File: rtl/symc_align.sv
module symc_align #(
  parameter int LINE_BYTES = 64,
  parameter int UNIT_BYTES = 4,
  localparam int UNITS     = LINE_BYTES / UNIT_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int UBITS     = UNIT_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_valid_i,
  input  logic [LINE_BITS-1:0] line_i,
  input  logic [OFF_W-1:0]     real_off_i,
  input  logic [OFF_W-1:0]     sym_off_i,
  output logic [LINE_BITS-1:0] line_o,
  output logic [UNITS-1:0]     umask_o
);

  int ru, su, shift_dist;

  always_comb begin
    ru = int'(real_off_i) / UNIT_BYTES;
    su = int'(sym_off_i) / UNIT_BYTES;
    shift_dist = (ru > su) ? (ru - su) : (su - ru);
    line_o  = '0;
    umask_o = '0;
    for (int j = 0; j < UNITS; j++) begin
      int k;
      k = j + ru - su;
      if (k >= 0 && k < UNITS) begin
        line_o[j*UBITS +: UBITS] = line_i[k*UBITS +: UBITS];
        umask_o[j] = 1'b1;
      end
    end
  end

  AST_FILL_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> ($countones(umask_o) == UNITS - shift_dist)); // R4

endmodule

// File: rtl/symc_lru.sv
module symc_lru #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] qa_set_i,
  input  logic [IDX_W-1:0] qb_set_i,
  output logic [WAY_W-1:0] victim_a_o,
  output logic [WAY_W-1:0] victim_b_o
);

  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  vic_a_vec, vic_b_vec;

  // age 0 = most recent, WAYS-1 = victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (w == int'(touch_way_i))
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_a_o = '0;
    victim_b_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      vic_a_vec[w] = (age_q[qa_set_i][w] == AGE_W'(WAYS-1));
      vic_b_vec[w] = (age_q[qb_set_i][w] == AGE_W'(WAYS-1));
      if (vic_a_vec[w]) victim_a_o = WAY_W'(w);
      if (vic_b_vec[w]) victim_b_o = WAY_W'(w);
    end
  end

  AST_ONE_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vic_a_vec) == 1 && $countones(vic_b_vec) == 1); // R8

  AST_TOUCH_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_set_i)][$past(touch_way_i)] == '0); // R8

endmodule

// File: rtl/symc_tag_match.sv
module symc_tag_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 12,
  parameter int UNITS  = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tags_i [WAYS],
  input  logic [UNITS-1:0] vld_i  [WAYS],
  input  logic [TAG_W-1:0] tag_i,
  output logic             any_o,
  output logic [WAY_W-1:0] way_o
);

  logic [WAYS-1:0] match;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = (tags_i[w] == tag_i) && (|vld_i[w]);
      if (match[w]) way_o = WAY_W'(w);
    end
    any_o = |match;
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(match) <= 1); // R7

endmodule

// File: rtl/symc_cache.sv
module symc_cache #(
  parameter int CAP_BYTES  = 4096,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 4,
  parameter int UNIT_BYTES = 4,
  parameter int SYM_W      = 22,
  localparam int SETS      = CAP_BYTES / (LINE_BYTES * WAYS),
  localparam int UNITS     = LINE_BYTES / UNIT_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = SYM_W - IDX_W - OFF_W,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int UIDX_W    = $clog2(UNITS),
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int DW        = symc_pkg::DATA_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_store_i,
  input  logic [1:0]           req_size_i,
  input  logic [SYM_W-1:0]     req_addr_i,
  input  logic [DW-1:0]        req_wdata_i,
  output logic                 hit_o,
  output logic [DW-1:0]        rdata_o,
  output logic                 miss_req_o,
  output logic [SYM_W-1:0]     miss_addr_o,
  input  logic                 fill_valid_i,
  input  logic [SYM_W-1:0]     fill_addr_i,
  input  logic [OFF_W-1:0]     fill_real_off_i,
  input  logic [LINE_BITS-1:0] fill_line_i
);
  import symc_pkg::*;

  localparam int NB = DATA_BYTES;

  logic [TAG_W-1:0]     tag_q  [SETS][WAYS];
  logic [UNITS-1:0]     vld_q  [SETS][WAYS];
  logic [LINE_BITS-1:0] data_q [SETS][WAYS];

  logic [OFF_W-1:0] r_off, f_off;
  logic [IDX_W-1:0] r_idx, f_idx;
  logic [TAG_W-1:0] r_tag, f_tag;
  assign {r_tag, r_idx, r_off} = req_addr_i;
  assign {f_tag, f_idx, f_off} = fill_addr_i;

  logic             r_any, f_any;
  logic [WAY_W-1:0] r_way, f_way, victim_a, victim_b;
  logic [WAY_W-1:0] st_way, fill_way;

  symc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .UNITS(UNITS)) u_req_match (
    .clk_i, .rst_ni,
    .tags_i(tag_q[r_idx]), .vld_i(vld_q[r_idx]), .tag_i(r_tag),
    .any_o(r_any), .way_o(r_way)
  );

  symc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .UNITS(UNITS)) u_fill_match (
    .clk_i, .rst_ni,
    .tags_i(tag_q[f_idx]), .vld_i(vld_q[f_idx]), .tag_i(f_tag),
    .any_o(f_any), .way_o(f_way)
  );

  // access decode: byte positions, covered units, read data
  int               nbytes;
  logic [OFF_W-1:0] pos [NB];
  logic [NB-1:0]    pos_en;
  logic [UNITS-1:0] need;
  logic [LINE_BITS-1:0] r_line;
  logic [DW-1:0]    rd_raw;
  logic             units_ok, load_hit, store_do;
  logic [UIDX_W-1:0] r_unit, f_unit;

  always_comb begin
    nbytes = size_bytes(acc_size_e'(req_size_i));
    r_line = data_q[r_idx][r_way];
    need   = '0;
    rd_raw = '0;
    for (int b = 0; b < NB; b++) begin
      pos[b]    = r_off + OFF_W'(b);
      pos_en[b] = (b < nbytes);
      if (pos_en[b]) begin
        need[int'(pos[b]) / UNIT_BYTES] = 1'b1;
        rd_raw[b*8 +: 8] = r_line[int'(pos[b])*8 +: 8];
      end
    end
    units_ok = ((need & ~vld_q[r_idx][r_way]) == '0);
    r_unit   = UIDX_W'(int'(r_off) / UNIT_BYTES);
    f_unit   = UIDX_W'(int'(f_off) / UNIT_BYTES);
  end

  assign load_hit    = req_valid_i && !req_store_i && r_any && units_ok;
  assign hit_o       = load_hit;
  assign rdata_o     = load_hit ? rd_raw : '0;
  assign miss_req_o  = req_valid_i && !req_store_i && !load_hit;
  assign miss_addr_o = req_addr_i;
  // fill owns the arrays when both arrive together
  assign store_do    = req_valid_i && req_store_i && !fill_valid_i;
  assign st_way      = r_any ? r_way : victim_a;
  assign fill_way    = f_any ? f_way : victim_b;

  logic             touch;
  logic [IDX_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  always_comb begin
    touch     = 1'b1;
    touch_set = r_idx;
    touch_way = r_way;
    if (fill_valid_i) begin
      touch_set = f_idx;
      touch_way = fill_way;
    end else if (store_do) begin
      touch_way = st_way;
    end else if (!load_hit) begin
      touch = 1'b0;
    end
  end

  symc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i, .rst_ni,
    .touch_i(touch), .touch_set_i(touch_set), .touch_way_i(touch_way),
    .qa_set_i(r_idx), .qb_set_i(f_idx),
    .victim_a_o(victim_a), .victim_b_o(victim_b)
  );

  logic [LINE_BITS-1:0] al_line;
  logic [UNITS-1:0]     al_mask;

  symc_align #(.LINE_BYTES(LINE_BYTES), .UNIT_BYTES(UNIT_BYTES)) u_align (
    .clk_i, .rst_ni,
    .fill_valid_i,
    .line_i(fill_line_i), .real_off_i(fill_real_off_i), .sym_off_i(f_off),
    .line_o(al_line), .umask_o(al_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= '0;
          tag_q[s][w] <= '0;
        end
    end else if (fill_valid_i) begin
      tag_q[f_idx][fill_way] <= f_tag;
      vld_q[f_idx][fill_way] <= al_mask;
    end else if (store_do) begin
      tag_q[r_idx][st_way] <= r_tag;
      vld_q[r_idx][st_way] <= (r_any ? vld_q[r_idx][st_way] : '0) | need;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) begin
      data_q[f_idx][fill_way] <= al_line;
    end else if (store_do) begin
      for (int b = 0; b < NB; b++)
        if (pos_en[b])
          data_q[r_idx][st_way][int'(pos[b])*8 +: 8] <= req_wdata_i[b*8 +: 8];
    end
  end

  AST_FILL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> vld_q[$past(f_idx)][$past(fill_way)][$past(f_unit)]); // R3

  AST_STORE_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_do |=> vld_q[$past(r_idx)][$past(st_way)][$past(r_unit)]); // R5

  AST_ALLOC_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_do && !r_any) |=> $countones(vld_q[$past(r_idx)][$past(st_way)]) <= NB); // R6

endmodule

// File: tb/symc_cache_test.sv
module symc_cache_test;

  localparam int SYM_W = 22;
  localparam int LB    = 64;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i, req_store_i;
  logic [1:0]       req_size_i;
  logic [SYM_W-1:0] req_addr_i, fill_addr_i;
  logic [31:0]      req_wdata_i;
  logic             fill_valid_i;
  logic [5:0]       fill_real_off_i;
  logic [LB*8-1:0]  fill_line_i;

  logic             hit_o, miss_req_o, b_hit, b_miss;
  logic [31:0]      rdata_o, b_rdata;
  logic [SYM_W-1:0] miss_addr_o, b_maddr;

  always #4 clk_i = ~clk_i;

  symc_cache uut (
    .clk_i, .rst_ni, .req_valid_i, .req_store_i, .req_size_i, .req_addr_i,
    .req_wdata_i, .hit_o, .rdata_o, .miss_req_o, .miss_addr_o,
    .fill_valid_i, .fill_addr_i, .fill_real_off_i, .fill_line_i
  );

  symc_cache #(.UNIT_BYTES(1)) uut_b (
    .clk_i, .rst_ni, .req_valid_i, .req_store_i, .req_size_i, .req_addr_i,
    .req_wdata_i, .hit_o(b_hit), .rdata_o(b_rdata), .miss_req_o(b_miss),
    .miss_addr_o(b_maddr),
    .fill_valid_i, .fill_addr_i, .fill_real_off_i, .fill_line_i
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  function automatic logic [SYM_W-1:0] sa(int t, int i, int o);
    return SYM_W'(t * 1024 + i * 64 + o);
  endfunction

  function automatic logic [LB*8-1:0] mkline(logic [7:0] seed);
    logic [LB*8-1:0] l;
    for (int p = 0; p < LB; p++) l[p*8 +: 8] = seed | 8'(p);
    return l;
  endfunction

  typedef struct packed {
    logic [1:0]       op;     // 0 fill, 1 store, 2 load
    logic [SYM_W-1:0] addr;
    logic [1:0]       size;
    logic [31:0]      arg;    // fill: {real_off, seed}; store: data
    logic             hit;
    logic [31:0]      data;
    logic [3:0]       rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{2'd2, sa(1,3,8),  2'd2, 32'h0,        1'b0, 32'h0,        4'd1},  // R1
    '{2'd0, sa(1,3,8),  2'd2, 32'h1440,     1'b0, 32'h0,        4'd3},
    '{2'd2, sa(1,3,8),  2'd2, 32'h0,        1'b1, 32'h57565554, 4'd3},  // R3
    '{2'd2, sa(1,3,0),  2'd2, 32'h0,        1'b1, 32'h4F4E4D4C, 4'd3},
    '{2'd2, sa(1,3,48), 2'd2, 32'h0,        1'b1, 32'h7F7E7D7C, 4'd4},  // R4
    '{2'd2, sa(1,3,52), 2'd2, 32'h0,        1'b0, 32'h0,        4'd4},
    '{2'd2, sa(1,3,9),  2'd0, 32'h0,        1'b1, 32'h00000055, 4'd2},  // R2
    '{2'd2, sa(1,3,10), 2'd1, 32'h0,        1'b1, 32'h00005756, 4'd2},
    '{2'd0, sa(2,5,40), 2'd2, 32'h0480,     1'b0, 32'h0,        4'd3},
    '{2'd2, sa(2,5,40), 2'd2, 32'h0,        1'b1, 32'h87868584, 4'd3},
    '{2'd2, sa(2,5,36), 2'd2, 32'h0,        1'b1, 32'h83828180, 4'd3},
    '{2'd2, sa(2,5,32), 2'd2, 32'h0,        1'b0, 32'h0,        4'd4},
    '{2'd1, sa(2,5,32), 2'd2, 32'hDEADBEEF, 1'b0, 32'h0,        4'd5},  // R5
    '{2'd2, sa(2,5,32), 2'd2, 32'h0,        1'b1, 32'hDEADBEEF, 4'd5},
    '{2'd1, sa(2,5,41), 2'd0, 32'h000000AA, 1'b0, 32'h0,        4'd5},
    '{2'd2, sa(2,5,40), 2'd2, 32'h0,        1'b1, 32'h8786AA84, 4'd5},
    '{2'd1, sa(3,5,0),  2'd2, 32'h12345678, 1'b0, 32'h0,        4'd6},  // R6
    '{2'd2, sa(3,5,0),  2'd2, 32'h0,        1'b1, 32'h12345678, 4'd6},
    '{2'd2, sa(3,5,4),  2'd2, 32'h0,        1'b0, 32'h0,        4'd6},
    '{2'd0, sa(2,5,60), 2'd2, 32'h00C0,     1'b0, 32'h0,        4'd7},  // R7
    '{2'd2, sa(2,5,60), 2'd2, 32'h0,        1'b1, 32'hC3C2C1C0, 4'd7},
    '{2'd2, sa(2,5,40), 2'd2, 32'h0,        1'b0, 32'h0,        4'd7},
    '{2'd2, sa(2,5,32), 2'd2, 32'h0,        1'b0, 32'h0,        4'd7},
    '{2'd0, sa(10,7,0), 2'd2, 32'h0,        1'b0, 32'h0,        4'd8},  // R8
    '{2'd0, sa(11,7,0), 2'd2, 32'h0,        1'b0, 32'h0,        4'd8},
    '{2'd0, sa(12,7,0), 2'd2, 32'h0,        1'b0, 32'h0,        4'd8},
    '{2'd0, sa(13,7,0), 2'd2, 32'h0,        1'b0, 32'h0,        4'd8},
    '{2'd2, sa(10,7,0), 2'd2, 32'h0,        1'b1, 32'h03020100, 4'd8},
    '{2'd0, sa(14,7,0), 2'd2, 32'h0040,     1'b0, 32'h0,        4'd8},
    '{2'd2, sa(11,7,0), 2'd2, 32'h0,        1'b0, 32'h0,        4'd8},
    '{2'd2, sa(10,7,0), 2'd2, 32'h0,        1'b1, 32'h03020100, 4'd8},
    '{2'd2, sa(12,7,0), 2'd2, 32'h0,        1'b1, 32'h03020100, 4'd8},
    '{2'd2, sa(13,7,0), 2'd2, 32'h0,        1'b1, 32'h03020100, 4'd8},
    '{2'd2, sa(14,7,0), 2'd2, 32'h0,        1'b1, 32'h43424140, 4'd8}
  };

  task automatic chk(int rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid_i = 1'b0; req_store_i = 1'b0; req_size_i = 2'd2;
    req_addr_i = '0; req_wdata_i = '0;
    fill_valid_i = 1'b0; fill_addr_i = '0; fill_real_off_i = '0; fill_line_i = '0;
  endtask

  task automatic load(logic [SYM_W-1:0] a, logic [1:0] sz);
    @(negedge clk_i); idle();
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz;
    #1;
  endtask

  task automatic fill(logic [SYM_W-1:0] a, logic [5:0] roff, logic [7:0] seed);
    fill_valid_i = 1'b1; fill_addr_i = a; fill_real_off_i = roff;
    fill_line_i = mkline(seed);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    load(sa(5,2,0), 2'd2);
    chk(1, "hit after reset", 32'(hit_o), 32'h0);
    chk(1, "rdata after reset", rdata_o, 32'h0);
    chk(1, "miss addr", 32'(miss_addr_o), 32'(sa(5,2,0)));

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i); idle();
      case (VECS[i].op)
        2'd0: fill(VECS[i].addr, VECS[i].arg[13:8], VECS[i].arg[7:0]);
        2'd1: begin
          req_valid_i = 1'b1; req_store_i = 1'b1; req_addr_i = VECS[i].addr;
          req_size_i = VECS[i].size; req_wdata_i = VECS[i].arg;
        end
        default: begin
          req_valid_i = 1'b1; req_addr_i = VECS[i].addr; req_size_i = VECS[i].size;
        end
      endcase
      #1;
      if (VECS[i].op == 2'd2) begin
        chk(int'(VECS[i].rq), $sformatf("vec %0d hit", i), 32'(hit_o), 32'(VECS[i].hit));
        chk(int'(VECS[i].rq), $sformatf("vec %0d miss", i), 32'(miss_req_o), 32'(!VECS[i].hit));
        chk(int'(VECS[i].rq), $sformatf("vec %0d data", i), rdata_o, VECS[i].data);
      end else if (VECS[i].op == 2'd1) begin
        chk(5, $sformatf("vec %0d store miss flag", i), 32'(miss_req_o), 32'h0);
      end
    end

    // R9: fill and store together, same line, then different set
    @(negedge clk_i); idle();
    fill(sa(20,9,0), 6'd0, 8'h40);
    req_valid_i = 1'b1; req_store_i = 1'b1; req_addr_i = sa(20,9,0); req_wdata_i = 32'h11111111;
    load(sa(20,9,0), 2'd2);
    chk(9, "fill wins data", rdata_o, 32'h43424140);
    @(negedge clk_i); idle();
    fill(sa(22,11,0), 6'd0, 8'h40);
    req_valid_i = 1'b1; req_store_i = 1'b1; req_addr_i = sa(21,10,0); req_wdata_i = 32'h55;
    load(sa(21,10,0), 2'd2);
    chk(9, "dropped store", 32'(hit_o), 32'h0);

    // R10: byte vs word granularity, sym off 2, real off 5
    @(negedge clk_i); idle();
    fill(sa(30,12,2), 6'd5, 8'h40);
    load(sa(30,12,2), 2'd0);
    chk(10, "byte unit target", b_rdata, 32'h00000045);
    load(sa(30,12,0), 2'd2);
    chk(10, "byte unit word", b_rdata, 32'h46454443);
    chk(10, "word unit word", rdata_o, 32'h47464544);
    load(sa(30,12,60), 2'd2);
    chk(10, "byte unit tail miss", 32'(b_miss), 32'h1);

    // R1: reset clears filled lines
    @(negedge clk_i); idle();
    rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    load(sa(10,7,0), 2'd2);
    chk(1, "miss after re-reset", 32'(miss_req_o), 32'h1);
    chk(1, "byte inst miss after re-reset", 32'(b_miss), 32'h1);

    @(negedge clk_i); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule